// File: doc/BRIEF.md
# Clock Frequency Monitor

This block watches two clocks against a slower internal RC reference clock: a crystal-oscillator clock and a PLL clock. The reference clock also clocks the block's own logic. A window timer in the reference domain cuts time into fixed windows of `2^WIN_LOG2` reference cycles. For each monitored clock, an edge counter runs in that clock's own domain. At every window boundary the counter is sampled and restarted through a two-flop toggle handshake. The resulting count, the number of monitored edges per window, is compared in the reference domain against the fault thresholds.

The crystal clock fails when its frequency falls below the reference divided by a programmable power of two. The PLL clock has three checks: above a programmable upper limit, below a programmable lower limit, and a loss-of-clock check below a fixed quarter of the reference rate. If a monitored clock stops, its handshake never completes. The window then reports a count of zero, and the first two results after the clock returns are discarded. Each check sets a sticky pending flag and emits a single-cycle failure pulse for reset and fault logic.

Every check runs only while its qualifying inputs have been true for two full window boundaries. For the crystal these are on and stable. For the PLL they are on, locked and the software enable bit.

Top module: `clk_freq_monitor`

## Requirements
- R1: After reset the control word reads 0, the upper limit reads 0xFFF, the lower limit reads 0, all pending flags are 0 and no failure pulse is driven.
- R2: Register map at `regAddr`: 0 = control (bit 0 PLL-check enable, bits 2:1 divider exponent `d`), 1 = upper limit [11:0], 2 = lower limit [11:0], 3 = pending flags [3:0]; written fields read back unchanged.
- R3: With a window of W reference cycles, a crystal count below `W >> d` sets pending bit 0 and pulses `evtXoscLoss`.
- R4: The crystal check raises nothing unless `xoscOn` and `xoscStable` are both 1.
- R5: A PLL count above the upper limit sets pending bit 1 and pulses `evtPllHigh`.
- R6: A PLL count below the lower limit sets pending bit 2 and pulses `evtPllLow`.
- R7: A PLL count below W/4 sets pending bit 3 and pulses `evtPllLoss`; a stopped PLL clock counts as zero.
- R8: The PLL checks raise nothing unless the enable bit, `pllOn` and `pllLocked` are all 1.
- R9: Pending flags stay set until 1 is written to the matching bit at address 3; a fault in the same cycle as that write leaves the flag set.
- R10: Each failure pulse lasts one cycle, comes at most once per window for as long as the fault persists, and the matching pending flag is 1 in the cycle the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC reference clock, also the register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xoscClk | input | 1 | Monitored crystal clock |
| pllClk | input | 1 | Monitored PLL clock |
| xoscOn | input | 1 | Crystal clock switched on |
| xoscStable | input | 1 | Crystal clock reported stable |
| pllOn | input | 1 | PLL clock switched on |
| pllLocked | input | 1 | PLL reported locked |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| irqPend | output | 4 | Sticky pending flags |
| evtXoscLoss | output | 1 | Crystal-too-slow failure pulse |
| evtPllHigh | output | 1 | PLL-above-limit failure pulse |
| evtPllLow | output | 1 | PLL-below-limit failure pulse |
| evtPllLoss | output | 1 | PLL loss-of-clock failure pulse |

## Verification
The assertions check on every cycle the properties of the pulses and flags themselves. They confirm that each failure pulse is one cycle wide, that its pending flag is set alongside it, and that a flag never rises without a pulse. They also confirm that flags hold until cleared, that a clear takes effect unless a fault coincides, and that no pulse appears unless its clock's qualifying inputs were true. The frequency decisions themselves can only be shown by the bench's scenarios. These decisions are the crystal comparison under each divider exponent, the upper, lower and quarter-rate PLL comparisons, the effect of the enable bit and a stopped PLL clock, and the case where a clear meets a fault in the same cycle. Each scenario sets real clock ratios and leaves out results that fall within two counts of a threshold.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  localparam int NUM_CH  = 2;
  localparam int CH_XOSC = 0;
  localparam int CH_PLL  = 1;

  localparam int NUM_EVT   = 4;
  localparam int EVT_XLOSS = 0;
  localparam int EVT_PHIGH = 1;
  localparam int EVT_PLOW  = 2;
  localparam int EVT_PLOSS = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_LOW  = 2'd2,
    ADDR_PEND = 2'd3
  } regAddr_e;

  // control -> datapath strobes
  typedef struct packed {
    logic winEnd;
  } ctrlStrobe_t;

  // datapath -> control comparison results, meaningful in the winEnd cycle
  typedef struct packed {
    logic xValid;
    logic xSlow;
    logic pValid;
    logic pHigh;
    logic pLow;
    logic pLoss;
  } measRes_t;

endpackage

// File: rtl/cfm_freq_meas.sv
// Edge counter in the monitored domain, sampled once per window through a
// toggle request / toggle acknowledge pair, each side resynchronised.
module cfm_freq_meas #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int SKIP_AFTER  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             monClk,
  input  logic             winEnd,
  output logic             measValid,
  output logic [CNT_W-1:0] measCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int SKIP_W = $clog2(SKIP_AFTER + 1);

  // ---------------- monitored clock domain ----------------
  logic [1:0]             mRst;
  logic                   mRstN;
  logic [SYNC_STAGES-1:0] reqSync;
  logic                   reqSeen;
  logic [CNT_W-1:0]       edgeCnt;
  logic [CNT_W-1:0]       holdCnt;
  logic                   ackTgl;
  logic                   reqTgl;

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) mRst <= 2'b00;
    else       mRst <= {mRst[0], 1'b1};
  end
  assign mRstN = mRst[1];

  always_ff @(posedge monClk or negedge mRstN) begin
    if (!mRstN) begin
      reqSync <= '0;
      reqSeen <= 1'b0;
      edgeCnt <= '0;
      holdCnt <= '0;
      ackTgl  <= 1'b0;
    end else begin
      reqSync <= {reqSync[SYNC_STAGES-2:0], reqTgl};
      reqSeen <= reqSync[SYNC_STAGES-1];
      if (reqSync[SYNC_STAGES-1] != reqSeen) begin
        holdCnt <= (edgeCnt == CNT_MAX) ? CNT_MAX : edgeCnt + 1'b1;
        edgeCnt <= '0;
        ackTgl  <= ~ackTgl;
      end else if (edgeCnt != CNT_MAX) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  // ---------------- reference clock domain ----------------
  logic [SYNC_STAGES-1:0] ackSync;
  logic                   ackSeen;
  logic                   ackArrive;
  logic                   outstanding;
  logic                   fresh;
  logic                   freshNow;
  logic                   stalled;
  logic [SKIP_W-1:0]      skipCnt;
  logic [CNT_W-1:0]       capCount;

  assign ackArrive = ackSync[SYNC_STAGES-1] != ackSeen;
  assign stalled   = outstanding && !ackArrive;
  assign freshNow  = ackArrive ? (skipCnt == '0) : fresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSync     <= '0;
      ackSeen     <= 1'b0;
      reqTgl      <= 1'b0;
      outstanding <= 1'b0;
      fresh       <= 1'b0;
      skipCnt     <= '0;
      capCount    <= '0;
    end else begin
      ackSync <= {ackSync[SYNC_STAGES-2:0], ackTgl};
      ackSeen <= ackSync[SYNC_STAGES-1];
      if (ackArrive) begin
        outstanding <= 1'b0;
        capCount    <= holdCnt;
        fresh       <= (skipCnt == '0);
        if (skipCnt != '0) skipCnt <= skipCnt - 1'b1;
      end
      if (winEnd) begin
        if (stalled) begin
          skipCnt <= SKIP_W'(SKIP_AFTER);
        end else begin
          reqTgl      <= ~reqTgl;
          outstanding <= 1'b1;
          fresh       <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    measValid = 1'b0;
    measCount = '0;
    if (winEnd) begin
      if (stalled) begin
        measValid = 1'b1;
      end else begin
        measValid = freshNow;
        measCount = ackArrive ? holdCnt : capCount;
      end
    end
  end

endmodule

// File: rtl/cfm_datapath.sv
module cfm_datapath import cfm_pkg::*; #(
  parameter int WIN_LOG2    = 6,
  parameter int CNT_W       = 12,
  parameter int DATA_W      = 16,
  parameter int RCDIV_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xoscClk,
  input  logic               pllClk,
  input  ctrlStrobe_t        strobe,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_EVT-1:0] pend,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_EVT-1:0] clrMask,
  output logic               pllEn,
  output measRes_t           meas
);

  localparam int WIN = 1 << WIN_LOG2;
  localparam logic [CNT_W-1:0] LOSS_TH = CNT_W'(WIN / 4);

  logic [RCDIV_W-1:0] rcDiv;
  logic [CNT_W-1:0]   hiRef;
  logic [CNT_W-1:0]   loRef;
  logic [CNT_W-1:0]   xThresh;
  logic [NUM_CH-1:0]  monClk;
  logic [NUM_CH-1:0]  chValid;
  logic [CNT_W-1:0]   chCount [NUM_CH];
  logic               unusedWdata;
  regAddr_e           addr;

  assign addr        = regAddr_e'(regAddr);
  assign unusedWdata = ^regWdata[DATA_W-1:CNT_W];

  assign monClk[CH_XOSC] = xoscClk;
  assign monClk[CH_PLL]  = pllClk;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_meas
    cfm_freq_meas #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_meas (
      .clk      (clk),
      .rstN     (rstN),
      .monClk   (monClk[ch]),
      .winEnd   (strobe.winEnd),
      .measValid(chValid[ch]),
      .measCount(chCount[ch])
    );
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllEn <= 1'b0;
      rcDiv <= '0;
      hiRef <= '1;
      loRef <= '0;
    end else if (regWe) begin
      case (addr)
        ADDR_CTRL: begin
          pllEn <= regWdata[0];
          rcDiv <= regWdata[RCDIV_W:1];
        end
        ADDR_HIGH: hiRef <= regWdata[CNT_W-1:0];
        ADDR_LOW:  loRef <= regWdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign clrMask = (regWe && addr == ADDR_PEND) ? regWdata[NUM_EVT-1:0] : '0;

  always_comb begin
    regRdata = '0;
    case (addr)
      ADDR_CTRL: regRdata[RCDIV_W:0]   = {rcDiv, pllEn};
      ADDR_HIGH: regRdata[CNT_W-1:0]   = hiRef;
      ADDR_LOW:  regRdata[CNT_W-1:0]   = loRef;
      default:   regRdata[NUM_EVT-1:0] = pend;
    endcase
  end

  // comparators
  assign xThresh     = CNT_W'(WIN >> rcDiv);
  assign meas.xValid = chValid[CH_XOSC];
  assign meas.xSlow  = chCount[CH_XOSC] < xThresh;
  assign meas.pValid = chValid[CH_PLL];
  assign meas.pHigh  = chCount[CH_PLL] > hiRef;
  assign meas.pLow   = chCount[CH_PLL] < loRef;
  assign meas.pLoss  = chCount[CH_PLL] < LOSS_TH;

endmodule

// File: rtl/cfm_ctrl.sv
module cfm_ctrl import cfm_pkg::*; #(
  parameter int WIN_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xoscOn,
  input  logic               xoscStable,
  input  logic               pllOn,
  input  logic               pllLocked,
  input  logic               pllEn,
  input  logic [NUM_EVT-1:0] clrMask,
  input  measRes_t           meas,
  output ctrlStrobe_t        strobe,
  output logic [NUM_EVT-1:0] pend,
  output logic [NUM_EVT-1:0] evt
);

  localparam logic [1:0] ARM_FULL = 2'd2;

  logic [WIN_LOG2-1:0] winCnt;
  logic                winEnd;
  logic [NUM_CH-1:0]   gate;
  logic [NUM_CH-1:0]   armed;
  logic [1:0]          arm [NUM_CH];
  logic [NUM_EVT-1:0]  faultNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else       winCnt <= winCnt + 1'b1;
  end
  assign winEnd        = &winCnt;
  assign strobe.winEnd = winEnd;

  assign gate[CH_XOSC] = xoscOn && xoscStable;
  assign gate[CH_PLL]  = pllOn && pllLocked && pllEn;

  // a check is armed once its gate has held across two window boundaries
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_arm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              arm[ch] <= '0;
      else if (!gate[ch])                     arm[ch] <= '0;
      else if (winEnd && arm[ch] != ARM_FULL) arm[ch] <= arm[ch] + 1'b1;
    end
    assign armed[ch] = gate[ch] && arm[ch] == ARM_FULL;
  end

  always_comb begin
    faultNow            = '0;
    faultNow[EVT_XLOSS] = winEnd && armed[CH_XOSC] && meas.xValid && meas.xSlow;
    faultNow[EVT_PHIGH] = winEnd && armed[CH_PLL] && meas.pValid && meas.pHigh;
    faultNow[EVT_PLOW]  = winEnd && armed[CH_PLL] && meas.pValid && meas.pLow;
    faultNow[EVT_PLOSS] = winEnd && armed[CH_PLL] && meas.pValid && meas.pLoss;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
      evt  <= '0;
    end else begin
      pend <= (pend & ~clrMask) | faultNow;
      evt  <= faultNow;
    end
  end

endmodule

// File: rtl/clk_freq_monitor.sv
module clk_freq_monitor import cfm_pkg::*; #(
  parameter int WIN_LOG2    = 6,
  parameter int CNT_W       = 12,
  parameter int DATA_W      = 16,
  parameter int RCDIV_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xoscClk,
  input  logic              pllClk,
  input  logic              xoscOn,
  input  logic              xoscStable,
  input  logic              pllOn,
  input  logic              pllLocked,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [3:0]        irqPend,
  output logic              evtXoscLoss,
  output logic              evtPllHigh,
  output logic              evtPllLow,
  output logic              evtPllLoss
);

  ctrlStrobe_t        strobe;
  measRes_t           meas;
  logic [NUM_EVT-1:0] clrMask;
  logic [NUM_EVT-1:0] pend;
  logic [NUM_EVT-1:0] evt;
  logic               pllEn;

  cfm_datapath #(
    .WIN_LOG2   (WIN_LOG2),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .RCDIV_W    (RCDIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .xoscClk (xoscClk),
    .pllClk  (pllClk),
    .strobe  (strobe),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .pend    (pend),
    .regRdata(regRdata),
    .clrMask (clrMask),
    .pllEn   (pllEn),
    .meas    (meas)
  );

  cfm_ctrl #(
    .WIN_LOG2(WIN_LOG2)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .xoscOn    (xoscOn),
    .xoscStable(xoscStable),
    .pllOn     (pllOn),
    .pllLocked (pllLocked),
    .pllEn     (pllEn),
    .clrMask   (clrMask),
    .meas      (meas),
    .strobe    (strobe),
    .pend      (pend),
    .evt       (evt)
  );

  assign irqPend     = pend;
  assign evtXoscLoss = evt[EVT_XLOSS];
  assign evtPllHigh  = evt[EVT_PHIGH];
  assign evtPllLow   = evt[EVT_PLOW];
  assign evtPllLoss  = evt[EVT_PLOSS];

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              xoscOn,
  input logic              xoscStable,
  input logic              pllOn,
  input logic              pllLocked,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [3:0]        irqPend,
  input logic              evtXoscLoss,
  input logic              evtPllHigh,
  input logic              evtPllLow,
  input logic              evtPllLoss
);

  logic [3:0] evtVec;
  assign evtVec = {evtPllLoss, evtPllLow, evtPllHigh, evtXoscLoss};

  // R4: crystal pulse only after a qualified cycle
  p_xosc_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    evtXoscLoss |-> $past(xoscOn && xoscStable));

  // R8: PLL pulses only after a qualified cycle
  p_pll_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evtPllHigh || evtPllLow || evtPllLoss) |-> $past(pllOn && pllLocked));

  for (genvar i = 0; i < 4; i++) begin : g_evt
    // R10: single-cycle pulse
    p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |=> !evtVec[i]);

    // R10: flag is set while its pulse is high
    p_evt_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |-> irqPend[i]);

    // R10: a flag only rises together with a pulse
    p_flag_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqPend[i]) |-> evtVec[i]);

    // R9: sticky without a clear
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      (irqPend[i] && !(regWe && regAddr == 2'd3 && regWdata[i])) |=> irqPend[i]);

    // R9: clear takes effect unless a fault coincides
    p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
      (irqPend[i] && regWe && regAddr == 2'd3 && regWdata[i]) |=> (!irqPend[i] || evtVec[i]));
  end

endmodule

bind clk_freq_monitor cfm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .xoscOn     (xoscOn),
  .xoscStable (xoscStable),
  .pllOn      (pllOn),
  .pllLocked  (pllLocked),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .irqPend    (irqPend),
  .evtXoscLoss(evtXoscLoss),
  .evtPllHigh (evtPllHigh),
  .evtPllLow  (evtPllLow),
  .evtPllLoss (evtPllLoss)
);

// File: tb/clk_freq_monitor_tb.sv
`timescale 1ns/1ps
module clk_freq_monitor_tb;

  localparam int WIN    = 64;
  localparam int DATA_W = 16;
  localparam int WDOG_CYCLES = 150000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic xoscClk = 1'b0, pllClk = 1'b0;
  realtime xHalf = 2.0, pHalf = 2.0;
  logic xRun = 1'b1, pRun = 1'b1;
  logic xoscOn = 1'b0, xoscStable = 1'b0, pllOn = 1'b0, pllLocked = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic [3:0] irqPend;
  logic evtXoscLoss, evtPllHigh, evtPllLow, evtPllLoss;

  always begin #(xHalf); if (xRun) xoscClk = ~xoscClk; end
  always begin #(pHalf); if (pRun) pllClk = ~pllClk; end

  clk_freq_monitor u_dut (
    .clk(clk), .rstN(rstN), .xoscClk(xoscClk), .pllClk(pllClk),
    .xoscOn(xoscOn), .xoscStable(xoscStable), .pllOn(pllOn), .pllLocked(pllLocked),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqPend(irqPend), .evtXoscLoss(evtXoscLoss), .evtPllHigh(evtPllHigh),
    .evtPllLow(evtPllLow), .evtPllLoss(evtPllLoss)
  );

  int errors = 0;
  int checks = 0;
  int evCnt [4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (evtXoscLoss) evCnt[0]++;
    if (evtPllHigh)  evCnt[1]++;
    if (evtPllLow)   evCnt[2]++;
    if (evtPllLoss)  evCnt[3]++;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkRange(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic regWrite(int addr, int data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'(addr); regWdata = DATA_W'(data);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(int addr, output int data);
    @(negedge clk);
    regAddr = 2'(addr);
    #1;
    data = int'(regRdata);
  endtask

  // 1 = fault expected, 0 = none, 2 = too close to call
  function automatic int expBelow(int c, int t);
    if (c <= t - 3) return 1;
    if (c >= t + 2) return 0;
    return 2;
  endfunction

  function automatic int expAbove(int c, int t);
    if (c >= t + 3) return 1;
    if (c <= t - 2) return 0;
    return 2;
  endfunction

  // xc/pc: edges per window; pc == 0 stops the PLL clock
  task automatic runCase(string tag, int xc, int pc, int rcd, int hi, int lo,
                         bit pEn, bit xOk, bit pOk);
    int ex [4];
    int snap [4];
    int rd;
    bit pG;
    string reqName [4];
    @(negedge clk);
    xoscOn = 1'b0; xoscStable = 1'b0; pllOn = 1'b0; pllLocked = 1'b0;
    xHalf = 128.0 / xc;
    if (pc == 0) pRun = 1'b0;
    else begin pRun = 1'b1; pHalf = 128.0 / pc; end
    regWrite(0, (rcd << 1) | int'(pEn));
    regWrite(1, hi);
    regWrite(2, lo);
    repeat (2 * WIN) @(negedge clk);
    regWrite(3, 15);
    for (int i = 0; i < 4; i++) snap[i] = evCnt[i];
    xoscOn = 1'b1; xoscStable = xOk; pllOn = 1'b1; pllLocked = pOk;
    repeat (8 * WIN) @(negedge clk);
    pG = pEn && pOk;
    ex[0] = xOk ? expBelow(xc, WIN >> rcd) : 0;
    ex[1] = pG ? expAbove(pc, hi) : 0;
    ex[2] = pG ? expBelow(pc, lo) : 0;
    ex[3] = pG ? expBelow(pc, WIN / 4) : 0;
    reqName[0] = xOk ? "R3" : "R4";
    reqName[1] = pG ? "R5" : "R8";
    reqName[2] = pG ? "R6" : "R8";
    reqName[3] = pG ? "R7" : "R8";
    regRead(3, rd);
    for (int i = 0; i < 4; i++) begin
      if (ex[i] != 2) begin
        check(reqName[i], $sformatf("%s pending bit %0d", tag, i), (rd >> i) & 1, ex[i]);
        if (ex[i] == 1)
          checkRange("R10", $sformatf("%s pulses ch%0d", tag, i), evCnt[i] - snap[i], 3, 8);
        else
          check(reqName[i], $sformatf("%s pulses ch%0d", tag, i), evCnt[i] - snap[i], 0);
      end
    end
    xoscOn = 1'b0; xoscStable = 1'b0; pllOn = 1'b0; pllLocked = 1'b0;
    pRun = 1'b1;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rd;
    int guard;
    void'($urandom(32'h5EED_C10C));
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    regRead(0, rd); check("R1", "ctrl reset", rd, 0);
    regRead(1, rd); check("R1", "upper reset", rd, 12'hFFF);
    regRead(2, rd); check("R1", "lower reset", rd, 0);
    regRead(3, rd); check("R1", "pending reset", rd, 0);
    check("R1", "pulses at reset", int'({evtXoscLoss, evtPllHigh, evtPllLow, evtPllLoss}), 0);

    // R2: readback
    regWrite(0, 16'h0005); regRead(0, rd); check("R2", "ctrl readback", rd, 5);
    regWrite(1, 16'hFABC); regRead(1, rd); check("R2", "upper readback", rd, 12'hABC);
    regWrite(2, 16'h0123); regRead(2, rd); check("R2", "lower readback", rd, 12'h123);

    // R3: crystal under each divider exponent
    runCase("xosc_slow_d0", 40, 64, 0, 4000, 0, 0, 1, 1);
    runCase("xosc_ok_d1", 40, 64, 1, 4000, 0, 0, 1, 1);
    runCase("xosc_slow_d3", 5, 64, 3, 4000, 0, 0, 1, 1);
    // R4: unstable crystal ignored
    runCase("xosc_unstable", 10, 64, 0, 4000, 0, 0, 0, 1);
    // R5, R6, R7
    runCase("pll_high", 70, 100, 0, 80, 0, 1, 1, 1);
    runCase("pll_low", 70, 50, 0, 4000, 70, 1, 1, 1);
    runCase("pll_loss", 70, 10, 0, 4000, 0, 1, 1, 1);
    // R8: enable off, then unlocked
    runCase("pll_disabled", 70, 10, 0, 20, 60, 0, 1, 1);
    runCase("pll_unlocked", 70, 10, 0, 20, 60, 1, 1, 0);
    // R7: stopped clock counts as zero
    runCase("pll_stopped", 70, 0, 0, 4000, 5, 1, 1, 1);

    // random mix
    for (int n = 0; n < 18; n++) begin
      runCase($sformatf("rnd%0d", n), 5 + int'($urandom % 80), 8 + int'($urandom % 150),
              int'($urandom % 4), int'($urandom % 200), int'($urandom % 120),
              ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
    end

    // R9: clear coinciding with a fault keeps the flag, plain clear removes it
    pHalf = 128.0 / 8;
    regWrite(0, 1);
    regWrite(1, 4000);
    regWrite(2, 0);
    xoscOn = 1'b0; pllOn = 1'b1; pllLocked = 1'b1;
    repeat (5 * WIN) @(negedge clk);
    regWe = 1'b1; regAddr = 2'd3; regWdata = 16'h0008;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!evtPllLoss && guard < 4 * WIN);
    regWe = 1'b0;
    check("R9", "loss pulse seen during clears", int'(evtPllLoss), 1);
    regRead(3, rd); check("R9", "flag kept on coincident clear", (rd >> 3) & 1, 1);
    regWrite(3, 8);
    regRead(3, rd); check("R9", "flag cleared by write-one", (rd >> 3) & 1, 0);
    pllOn = 1'b0; pllLocked = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule